// File: doc/BRIEF.md
# Register hazard scoreboard queue

This block sits beside the decode stage of an in-order pipeline and remembers which registers are about to be written by instructions that have already left decode but have not yet committed. Every decoded instruction pushes one entry holding its destination register, or an empty marker when it writes nothing. Every committing instruction pops the oldest entry, so the queue always mirrors program order.

Decode asks two questions each cycle, one per source operand: "is this register still owed by an older instruction?". Both answers come back combinationally, in parallel, over all live entries. A pop in the same cycle is seen by both questions, so a producer that commits in cycle N no longer holds up a consumer decoded in cycle N. Likewise a full queue accepts a push in a cycle in which it pops.

Top module: `sbq_scoreboard`

## Requirements
- R1: After synchronous reset the queue is empty: `ins_ready` is 1 and neither search port reports a hit for any register.
- R2: After an entry with a valid destination D has been pushed, port 1 hits when queried with D and port 2 hits when queried with D, each independently of what the other port is asked.
- R3: A hit requires three things: the query valid bit is 1, the stored entry was pushed with `ins_has_dst` = 1, and the indices are equal. An invalid query, an entry pushed without a destination, or a different index gives no hit.
- R4: A pop always removes the oldest live entry; younger entries remain searchable.
- R5: When the same register is held by several live entries, it keeps hitting until the last of them is popped.
- R6: An entry popped in a cycle is already excluded from that same cycle's searches.
- R7: With all DEPTH slots occupied and `rem_en` = 0, `ins_ready` is 0 and a push is dropped: its register never becomes searchable.
- R8: With all slots occupied and `rem_en` = 1, `ins_ready` is 1 and the push is accepted in that cycle.
- R9: A pop on an empty queue is ignored: it leaves no trace, and later pushes and pops behave as from empty.
- R10: Slots that are not occupied never match, even when they still hold an old register index from earlier traffic.
- R11: A push is not visible to the searches of the cycle it is made in; it becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Push one entry this cycle |
| ins_has_dst | input | 1 | The pushed instruction writes a register |
| ins_dst | input | IDX_W | Destination register index of the push |
| rem_en | input | 1 | Pop the oldest entry this cycle |
| s1_vld | input | 1 | Source 1 query is meaningful |
| s1_reg | input | IDX_W | Source 1 register index |
| s2_vld | input | 1 | Source 2 query is meaningful |
| s2_reg | input | IDX_W | Source 2 register index |
| s1_hit | output | 1 | Source 1 is owed by a live entry |
| s2_hit | output | 1 | Source 2 is owed by a live entry |
| ins_ready | output | 1 | A push this cycle will be accepted |

## Verification
The bench targets the same-cycle interactions: a pop hiding its own entry from the searches, a push staying invisible until the next cycle, and a full queue taking a push only while popping; a design that ordered these wrongly would stall a consumer behind a finished producer, or overwrite the oldest entry. It repeats a register in two entries to catch a design that clears a hazard on the first pop, and pushes entries without a destination to catch one that matches on the index alone. After draining it probes registers left behind in the slots, which a design that ignored occupancy would keep reporting, and it pops an empty queue, which a careless pointer would turn into a lost or phantom entry.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  localparam int SBQ_DEF_DEPTH = 4;
  localparam int SBQ_DEF_IDX_W = 5;

  function automatic int sbq_ptr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/sbq_ctrl.sv
module sbq_ctrl #(
  parameter int DEPTH = sbq_pkg::SBQ_DEF_DEPTH,
  localparam int PW   = sbq_pkg::sbq_ptr_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_req,
  input  logic             rem_req,
  input  logic [DEPTH-1:0] occ,
  output logic [PW-1:0]    head,
  output logic [PW-1:0]    tail,
  output logic             ins_fire,
  output logic             rem_fire,
  output logic             ins_ready,
  output logic [DEPTH-1:0] live
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic full;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full      = &occ;
  assign rem_fire  = rem_req && occ[head];
  assign ins_ready = !full || rem_fire;
  assign ins_fire  = ins_req && ins_ready;
  assign live      = rem_fire ? (occ & ~(DEPTH'(1) << head)) : occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (rem_fire) head <= bump(head);
      if (ins_fire) tail <= bump(tail);
    end
  end
endmodule

// File: rtl/sbq_store.sv
module sbq_store #(
  parameter int DEPTH = sbq_pkg::SBQ_DEF_DEPTH,
  parameter int IDX_W = sbq_pkg::SBQ_DEF_IDX_W,
  localparam int PW   = sbq_pkg::sbq_ptr_w(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ins_fire,
  input  logic                   rem_fire,
  input  logic [PW-1:0]          head,
  input  logic [PW-1:0]          tail,
  input  logic                   ins_has_dst,
  input  logic [IDX_W-1:0]       ins_dst,
  output logic [DEPTH-1:0]       occ,
  output logic [DEPTH-1:0]       ent_vld,
  output logic [DEPTH*IDX_W-1:0] ent_idx
);
  logic             vld_q [DEPTH];
  logic [IDX_W-1:0] idx_q [DEPTH];

  // occupancy carries the reset; slot contents need none
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      if (rem_fire) occ[head] <= 1'b0;
      if (ins_fire) occ[tail] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      vld_q[tail] <= ins_has_dst;
      idx_q[tail] <= ins_dst;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign ent_vld[g]                 = vld_q[g];
    assign ent_idx[g*IDX_W +: IDX_W]  = idx_q[g];
  end
endmodule

// File: rtl/sbq_search.sv
module sbq_search #(
  parameter int DEPTH = sbq_pkg::SBQ_DEF_DEPTH,
  parameter int IDX_W = sbq_pkg::SBQ_DEF_IDX_W
) (
  input  logic [DEPTH-1:0]       live,
  input  logic [DEPTH-1:0]       ent_vld,
  input  logic [DEPTH*IDX_W-1:0] ent_idx,
  input  logic                   q_vld,
  input  logic [IDX_W-1:0]       q_idx,
  output logic                   hit
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = live[g] && ent_vld[g] &&
                      (ent_idx[g*IDX_W +: IDX_W] == q_idx);
  end

  assign hit = q_vld && (|match);
endmodule

// File: rtl/sbq_scoreboard.sv
module sbq_scoreboard #(
  parameter int DEPTH = sbq_pkg::SBQ_DEF_DEPTH,
  parameter int IDX_W = sbq_pkg::SBQ_DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic             ins_has_dst,
  input  logic [IDX_W-1:0] ins_dst,
  input  logic             rem_en,
  input  logic             s1_vld,
  input  logic [IDX_W-1:0] s1_reg,
  input  logic             s2_vld,
  input  logic [IDX_W-1:0] s2_reg,
  output logic             s1_hit,
  output logic             s2_hit,
  output logic             ins_ready
);
  localparam int PW = sbq_pkg::sbq_ptr_w(DEPTH);

  logic [PW-1:0]          head, tail;
  logic                   ins_fire, rem_fire;
  logic [DEPTH-1:0]       occ, live, ent_vld;
  logic [DEPTH*IDX_W-1:0] ent_idx;
  logic [1:0]             q_vld, hit;
  logic [IDX_W-1:0]       q_idx [2];

  sbq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .ins_req(ins_en), .rem_req(rem_en), .occ(occ),
    .head(head), .tail(tail), .ins_fire(ins_fire), .rem_fire(rem_fire),
    .ins_ready(ins_ready), .live(live)
  );

  sbq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .ins_fire(ins_fire), .rem_fire(rem_fire),
    .head(head), .tail(tail), .ins_has_dst(ins_has_dst), .ins_dst(ins_dst),
    .occ(occ), .ent_vld(ent_vld), .ent_idx(ent_idx)
  );

  assign q_vld    = {s2_vld, s1_vld};
  assign q_idx[0] = s1_reg;
  assign q_idx[1] = s2_reg;

  for (genvar p = 0; p < 2; p++) begin : g_port
    sbq_search #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_search (
      .live(live), .ent_vld(ent_vld), .ent_idx(ent_idx),
      .q_vld(q_vld[p]), .q_idx(q_idx[p]), .hit(hit[p])
    );
  end

  assign s1_hit = hit[0];
  assign s2_hit = hit[1];
endmodule

// File: rtl/sbq_scoreboard_chk.sv
module sbq_scoreboard_chk #(
  parameter int DEPTH = sbq_pkg::SBQ_DEF_DEPTH,
  parameter int IDX_W = sbq_pkg::SBQ_DEF_IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_en,
  input logic             ins_has_dst,
  input logic [IDX_W-1:0] ins_dst,
  input logic             rem_en,
  input logic             s1_vld,
  input logic [IDX_W-1:0] s1_reg,
  input logic             s2_vld,
  input logic [IDX_W-1:0] s2_reg,
  input logic             s1_hit,
  input logic             s2_hit,
  input logic             ins_ready
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok;

  assign pop_ok  = rem_en && (cnt != '0);
  assign push_ok = ins_en && ins_ready;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
  end

  assert_empty_nohit_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (!s1_hit && !s2_hit));

  assert_push_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (ins_en && ins_ready && ins_has_dst) ##1
    (!rem_en && s1_vld && s1_reg == $past(ins_dst)) |-> s1_hit);

  assert_invalid_query_R3: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld |-> !s1_hit) and (!s2_vld |-> !s2_hit));

  assert_port_agree_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_vld == s2_vld && s1_reg == s2_reg) |-> (s1_hit == s2_hit));

  assert_pop_hides_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1) && rem_en) |-> (!s1_hit && !s2_hit));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH) && !rem_en) |-> !ins_ready);

  assert_full_swap_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && rem_en) |-> ins_ready);

  assert_room_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt < CW'(DEPTH)) |-> ins_ready);
endmodule

bind sbq_scoreboard sbq_scoreboard_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sbq_scoreboard_tb.sv
module sbq_scoreboard_tb;
  localparam int DEPTH = 4;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_en = 0, ins_has_dst = 0, rem_en = 0;
  logic s1_vld = 0, s2_vld = 0;
  logic [IDX_W-1:0] ins_dst = '0, s1_reg = '0, s2_reg = '0;
  logic s1_hit, s2_hit, ins_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sbq_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dut (.*);

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; outputs settle 1 ns later
  task automatic drive(input logic ie, input logic hd, input int d, input logic re,
                       input logic v1, input int r1, input logic v2, input int r2);
    @(negedge clk);
    ins_en = ie; ins_has_dst = hd; ins_dst = IDX_W'(d); rem_en = re;
    s1_vld = v1; s1_reg = IDX_W'(r1); s2_vld = v2; s2_reg = IDX_W'(r2);
    #1;
  endtask

  task automatic push(input int d);
    drive(1, 1, d, 0, 0, 0, 0, 0);
  endtask

  task automatic pop();
    drive(0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic probe(input int r1, input int r2, input logic e1, input logic e2,
                       input string tag);
    drive(0, 0, 0, 0, 1, r1, 1, r2);
    chk(s1_hit, e1, {tag, " port1"});
    chk(s2_hit, e2, {tag, " port2"});
  endtask

  task automatic t_reset();
    probe(3, 0, 0, 0, "R1 empty after reset");
    chk(ins_ready, 1, "R1 ready after reset");
  endtask

  task automatic t_basic();
    drive(1, 1, 5, 0, 1, 5, 1, 5);
    chk(s1_hit, 0, "R11 push not seen same cycle p1");
    chk(s2_hit, 0, "R11 push not seen same cycle p2");
    probe(5, 7, 1, 0, "R2 port1 alone");
    probe(7, 5, 0, 1, "R2 port2 alone");
    drive(0, 0, 0, 0, 0, 5, 1, 6);
    chk(s1_hit, 0, "R3 invalid query");
    chk(s2_hit, 0, "R3 index differs");
    drive(1, 0, 9, 0, 0, 0, 0, 0);
    probe(9, 9, 0, 0, "R3 entry without destination");
    drive(0, 0, 0, 1, 1, 5, 0, 0);
    chk(s1_hit, 0, "R6 popped entry hidden");
    pop();
  endtask

  task automatic t_order();
    push(1); push(2); push(3);
    drive(0, 0, 0, 1, 1, 1, 1, 2);
    chk(s1_hit, 0, "R4/R6 oldest leaving");
    chk(s2_hit, 1, "R4 younger stays");
    probe(1, 3, 0, 1, "R4 after pop");
    pop(); pop();
    probe(2, 3, 0, 0, "R4 all drained");
  endtask

  task automatic t_dup();
    push(4); push(4);
    pop();
    probe(4, 4, 1, 1, "R5 duplicate persists");
    pop();
    probe(4, 4, 0, 0, "R5 cleared by last pop");
  endtask

  task automatic t_full();
    push(10); push(11); push(12); push(13);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(ins_ready, 0, "R7 full not ready");
    drive(1, 1, 14, 0, 0, 0, 0, 0);
    chk(ins_ready, 0, "R7 refused push");
    drive(1, 1, 15, 1, 1, 10, 0, 0);
    chk(ins_ready, 1, "R8 full with pop ready");
    chk(s1_hit, 0, "R8/R6 head hidden during swap");
    probe(14, 15, 0, 1, "R7/R8 refused vs accepted");
    probe(10, 11, 0, 1, "R8 head gone");
    pop(); pop(); pop();
    probe(15, 13, 1, 0, "R8 swapped entry last");
    pop();
    probe(15, 14, 0, 0, "R8 drained");
  endtask

  task automatic t_empty_pop();
    pop();
    push(20); push(21);
    pop();
    probe(20, 21, 0, 1, "R9 empty pop ignored");
    pop();
    probe(21, 20, 0, 0, "R9 drained");
  endtask

  task automatic t_stale();
    probe(13, 12, 0, 0, "R10 stale slots");
    probe(11, 1, 0, 0, "R10 stale slots again");
    chk(ins_ready, 1, "R10 empty ready");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_basic();
    t_order();
    t_dup();
    t_full();
    t_empty_pop();
    t_stale();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule